// File: doc/BRIEF.md
# Model-Specific-Register Access Intercept Checker

This block decides whether a guest's read or write of a model-specific register may go ahead or must trap to the hypervisor. A request carries a 32-bit register index, a direction flag, an enable for bitmap-based filtering and the physical base address of a 4-KByte permission bitmap. The block checks the request, works out which bitmap byte and bit govern it, reads that byte over a single-outstanding memory read port, and returns a trap or permit answer on a valid/ready response channel.

The bitmap is split into four 1-KByte quadrants. The access direction and the index range pick the quadrant. Two index windows are covered: a low one from 0x00000000 to 0x00001FFF and a high one from 0xC0000000 to 0xC0001FFF. Software can rewrite the bitmap at any time, so the block keeps no copy of it and reads memory again on every check. Requests that are decided without the bitmap skip the memory read: filtering disabled, a misaligned base, or an index outside both windows.

Top module: `msrg_top`

## Requirements
- R1: After reset the block is idle: `req_ready` is 1, and `mem_req_valid` and `rsp_valid` are 0.
- R2: When `req_bm_en` is 0, the response is a trap (`rsp_trap`=1, `rsp_err`=0) and no memory read is issued.
- R3: When `req_bm_en` is 1 and `req_base[11:0]` is not zero, the response is a trap with `rsp_err`=1 and no memory read is issued.
- R4: When filtering is enabled, the base is aligned, and `req_index[31:13]` is neither 0 nor 0x60000, the response is a trap with `rsp_err`=0 and no memory read is issued.
- R5: For a covered index, the byte read is `req_base + Q*1024 + req_index[12:3]`. Q is 0 for a low-window read, 1 for a high-window read, 2 for a low-window write and 3 for a high-window write (`req_write`=1 means write).
- R6: The decision uses bit `req_index[2:0]` of the returned byte, where bit 0 is the least significant bit. A 1 gives a trap and a 0 gives a permit (`rsp_trap`=0). `rsp_err` is 0 in both cases.
- R7: A read answered with `mem_rsp_err`=1 gives `rsp_trap`=1 and `rsp_err`=1, whatever the returned data.
- R8: While `rsp_valid` is 1 and `rsp_ready` is 0, the response stays valid with `rsp_trap` and `rsp_err` unchanged.
- R9: Only one request is in flight at a time. `req_ready` is 1 only when neither a memory read nor a response is pending. A memory read request holds its address until `mem_req_ready` accepts it.
- R10: Every check reads memory again. Two identical requests give different answers when the bitmap byte changes between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and accepting a request |
| req_index | input | 32 | Register index |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_bm_en | input | 1 | Bitmap filtering enabled |
| req_base | input | 32 | Bitmap base address |
| mem_req_valid | output | 1 | Bitmap byte read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address to read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 8 | Returned bitmap byte |
| mem_rsp_err | input | 1 | Read failed |
| rsp_valid | output | 1 | Decision present |
| rsp_ready | input | 1 | Decision accepted |
| rsp_trap | output | 1 | 1 = trap, 0 = permit |
| rsp_err | output | 1 | Trap caused by a fault (misaligned base or memory error) |

## Verification
The assertions check the handshake rules on every cycle. A pending memory read and a pending response must hold steady until they are taken. An accepted request must never overlap a pending read. A request that needs no bitmap must produce its answer in the very next cycle, and a misaligned base must produce an error trap. Only the bench's scenarios can show the contents of each answer. These are the quadrant and byte address chosen for each direction and window, the bit tested within the byte, the effect of a failed read, and the fact that a changed bitmap byte changes a repeated answer. For these the bench compares the ports against its own model of the bitmap image.

// File: rtl/msrg_pkg.sv
// Package msrg_pkg: shared constants and the state type for the intercept checker.
// Assumes 1-KByte quadrants inside a 4-KByte bitmap and one bit per register index.
package msrg_pkg;
    localparam int SPAN_BITS = 13;                       // index bits covered per window
    localparam int PAGE_BITS = 12;                       // 4-KByte bitmap alignment
    localparam logic [31:0] HIGH_FIRST = 32'hC000_0000;  // first index of the high window

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_RESP  = 2'd2
    } msrg_state_e;
endpackage

// File: rtl/msrg_locate.sv
// Module msrg_locate: combinational address math for one request.
// It classifies the index into the low or high window, checks the base alignment,
// and forms the byte address and bit select inside the bitmap.
// Assumes the base is only used when base_ok is 1, so the offset can be OR-ed in.
module msrg_locate #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 32
) (
    input  logic [IDX_W-1:0]  index,
    input  logic              is_write,
    input  logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] byte_addr,
    output logic [2:0]        bit_sel,
    output logic              in_range,
    output logic              base_ok
);
    import msrg_pkg::*;

    localparam int HI_W = IDX_W - SPAN_BITS;
    localparam logic [IDX_W-1:0] HI_FIRST = IDX_W'(HIGH_FIRST);

    logic [HI_W-1:0]      upper;
    logic                 is_low;
    logic                 is_high;
    logic [PAGE_BITS-1:0] offset;

    // Window classification from the index bits above the covered span.
    always_comb begin
        upper   = index[IDX_W-1:SPAN_BITS];
        is_low  = (upper == '0);
        is_high = (upper == HI_FIRST[IDX_W-1:SPAN_BITS]);
        in_range = is_low | is_high;
    end

    // Quadrant select {direction, window} followed by the byte within the quadrant.
    always_comb begin
        offset    = {is_write, is_high, index[SPAN_BITS-1:3]};
        bit_sel   = index[2:0];
        base_ok   = (base[PAGE_BITS-1:0] == '0);
        byte_addr = {base[ADDR_W-1:PAGE_BITS], offset};
    end
endmodule

// File: rtl/msrg_seq.sv
// Module msrg_seq: request sequencer for the intercept checker.
// It accepts one request while idle and either answers at once (no bitmap needed)
// or issues one byte read, waits for the data and answers from the selected bit.
// Assumes the memory returns exactly one response per accepted read, after acceptance.
module msrg_seq #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              need_fetch,
    input  logic              pre_err,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic [2:0]        fetch_bit,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [7:0]        mem_rsp_data,
    input  logic              mem_rsp_err,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic              rsp_trap,
    output logic              rsp_err
);
    import msrg_pkg::*;

    msrg_state_e       state;
    logic              sent;
    logic [ADDR_W-1:0] addr_q;
    logic [2:0]        bit_q;
    logic              trap_q;
    logic              err_q;

    // State, captured request fields and the registered decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            sent   <= 1'b0;
            addr_q <= '0;
            bit_q  <= '0;
            trap_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        addr_q <= fetch_addr;
                        bit_q  <= fetch_bit;
                        sent   <= 1'b0;
                        if (need_fetch) begin
                            state <= ST_FETCH;
                        end else begin
                            trap_q <= 1'b1;
                            err_q  <= pre_err;
                            state  <= ST_RESP;
                        end
                    end
                end
                ST_FETCH: begin
                    if (mem_req_valid && mem_req_ready) begin
                        sent <= 1'b1;
                    end
                    if (sent && mem_rsp_valid) begin
                        trap_q <= mem_rsp_err | mem_rsp_data[bit_q];
                        err_q  <= mem_rsp_err;
                        state  <= ST_RESP;
                    end
                end
                ST_RESP: begin
                    if (rsp_ready) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Handshake outputs decoded from the state.
    always_comb begin
        req_ready     = (state == ST_IDLE);
        mem_req_valid = (state == ST_FETCH) && !sent;
        mem_req_addr  = addr_q;
        rsp_valid     = (state == ST_RESP);
        rsp_trap      = trap_q;
        rsp_err       = err_q;
    end

    // R8: a pending decision stays put until taken.
    a_r8_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_trap) && $stable(rsp_err));

    // R9: a pending read keeps its address until accepted.
    a_r9_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    // R9: never idle-ready while a read or decision is outstanding.
    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req_valid && !rsp_valid);

    // R4: a request that needs no bitmap is answered next cycle as a trap.
    a_r4_skip_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !need_fetch |=> rsp_valid && rsp_trap && !mem_req_valid);

    // R3: a misaligned base yields an error trap.
    a_r3_misalign_err: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && pre_err |=> rsp_err && rsp_trap);
endmodule

// File: rtl/msrg_top.sv
// Module msrg_top: model-specific-register access intercept checker.
// It combines the address math with the sequencer and forms the early-exit conditions
// (filtering disabled, misaligned base, index outside both windows).
// Assumes the requester holds its request fields stable while req_valid is 1.
module msrg_top #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [IDX_W-1:0]  req_index,
    input  logic              req_write,
    input  logic              req_bm_en,
    input  logic [ADDR_W-1:0] req_base,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [7:0]        mem_rsp_data,
    input  logic              mem_rsp_err,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic              rsp_trap,
    output logic              rsp_err
);
    logic [ADDR_W-1:0] byte_addr;
    logic [2:0]        bit_sel;
    logic              in_range;
    logic              base_ok;
    logic              need_fetch;
    logic              pre_err;

    msrg_locate #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_locate (
        .index     (req_index),
        .is_write  (req_write),
        .base      (req_base),
        .byte_addr (byte_addr),
        .bit_sel   (bit_sel),
        .in_range  (in_range),
        .base_ok   (base_ok)
    );

    // Early-exit decode: a read is needed only for an enabled, aligned, covered request.
    always_comb begin
        need_fetch = req_bm_en && base_ok && in_range;
        pre_err    = req_bm_en && !base_ok;
    end

    msrg_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .need_fetch    (need_fetch),
        .pre_err       (pre_err),
        .fetch_addr    (byte_addr),
        .fetch_bit     (bit_sel),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .mem_rsp_err   (mem_rsp_err),
        .rsp_valid     (rsp_valid),
        .rsp_ready     (rsp_ready),
        .rsp_trap      (rsp_trap),
        .rsp_err       (rsp_err)
    );

    // R2: with filtering off no read follows acceptance.
    a_r2_no_read_off: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !req_bm_en |=> !mem_req_valid);
endmodule

// File: tb/test_msrg_top.sv
module test_msrg_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_index = '0;
    logic        req_write = 1'b0;
    logic        req_bm_en = 1'b0;
    logic [31:0] req_base = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [7:0]  mem_rsp_data = '0;
    logic        mem_rsp_err = 1'b0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic        rsp_trap;
    logic        rsp_err;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    logic [7:0] img [0:4095];
    bit exp_fetch = 0;
    logic [31:0] exp_addr = '0;
    bit mon_on = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    msrg_top i_msrg_top (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_index(req_index),
        .req_write(req_write), .req_bm_en(req_bm_en), .req_base(req_base),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_trap(rsp_trap), .rsp_err(rsp_err)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
            $display("test done: total=%0d bad=%0d", total + 1, bad + 1);
            $finish;
        end
    end

    // Per-cycle model comparison of the handshake and read address.
    always @(negedge clk) begin
        if (mon_on) begin
            if (req_ready)
                chk(!mem_req_valid && !rsp_valid, "R9 ready while busy", {mem_req_valid, rsp_valid}, 0);
            if (mem_req_valid) begin
                chk(exp_fetch, "R2/R3/R4 unexpected read", 1, 0);
                chk(mem_req_addr == exp_addr, "R5 read address", mem_req_addr, exp_addr);
            end
        end
    end

    // Runs one request through the block acting as memory and consumer.
    task automatic run(input logic [31:0] idx, input bit wr, input bit en, input logic [31:0] base,
                       input int lat, input bit merr, input int hold, input string tag);
        bit ok_base, in_rng, hi;
        int off;
        bit etrap, eerr;
        logic [7:0] b;
        ok_base = (base % 4096) == 0;
        hi = (idx >= 32'hC000_0000) && (idx <= 32'hC000_1FFF);
        in_rng = (idx <= 32'h1FFF) || hi;
        exp_fetch = en && ok_base && in_rng;
        off = (wr ? 2048 : 0) + (hi ? 1024 : 0) + int'(idx % 8192) / 8;
        exp_addr = base + off;
        if (!exp_fetch) begin
            etrap = 1; eerr = en && !ok_base;
        end else begin
            b = img[off];
            etrap = merr || b[idx % 8];
            eerr = merr;
        end
        @(negedge clk);
        req_valid = 1; req_index = idx; req_write = wr; req_bm_en = en; req_base = base;
        chk(req_ready == 1, {tag, " idle ready"}, req_ready, 1);
        @(negedge clk);
        req_valid = 0;
        if (exp_fetch) begin
            for (int k = 0; k < 30 && !mem_req_valid; k++) @(negedge clk);
            chk(mem_req_valid == 1, {tag, " read issued"}, mem_req_valid, 1);
            @(negedge clk);
            chk(mem_req_valid == 1, "R9 read held", mem_req_valid, 1);
            mem_req_ready = 1;
            @(negedge clk);
            mem_req_ready = 0;
            chk(mem_req_valid == 0, "R9 single read", mem_req_valid, 0);
            for (int k = 0; k < lat; k++) @(negedge clk);
            mem_rsp_valid = 1; mem_rsp_err = merr; mem_rsp_data = merr ? 8'hA5 : img[off];
            @(negedge clk);
            mem_rsp_valid = 0; mem_rsp_err = 0;
        end
        for (int k = 0; k < 30 && !rsp_valid; k++) @(negedge clk);
        chk(rsp_valid == 1, {tag, " response"}, rsp_valid, 1);
        chk(rsp_trap == etrap, {tag, " trap"}, rsp_trap, etrap);
        chk(rsp_err == eerr, {tag, " err"}, rsp_err, eerr);
        for (int k = 0; k < hold; k++) begin
            @(negedge clk);
            chk(rsp_valid && rsp_trap == etrap && rsp_err == eerr, "R8 hold", {rsp_valid, rsp_trap, rsp_err}, {1'b1, etrap, eerr});
        end
        rsp_ready = 1;
        @(negedge clk);
        rsp_ready = 0;
        chk(!rsp_valid && req_ready, "R9 back to idle", {rsp_valid, req_ready}, 1);
        exp_fetch = 0;
    endtask

    localparam logic [31:0] BASE = 32'h0004_3000;

    initial begin
        for (int i = 0; i < 4096; i++) img[i] = 8'((i * 73 + 29) & 255);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk(req_ready == 1 && !mem_req_valid && !rsp_valid, "R1 reset state",
            {req_ready, mem_req_valid, rsp_valid}, 3'b100);
        mon_on = 1;
        // R2: filtering disabled
        run(32'h0000_0010, 0, 0, BASE, 1, 0, 0, "R2 off read");
        run(32'hC000_0001, 1, 0, BASE, 1, 0, 0, "R2 off write");
        // R3: misaligned base
        run(32'h0000_0010, 0, 1, BASE + 32'h10, 1, 0, 0, "R3 misaligned");
        run(32'hC000_0100, 1, 1, BASE + 32'h800, 1, 0, 0, "R3 misaligned");
        // R4: outside both windows
        run(32'h0000_2000, 0, 1, BASE, 1, 0, 0, "R4 above low");
        run(32'hBFFF_FFFF, 0, 1, BASE, 1, 0, 0, "R4 below high");
        run(32'hC000_2000, 1, 1, BASE, 1, 0, 0, "R4 above high");
        run(32'h4000_0000, 1, 1, BASE, 1, 0, 0, "R4 middle");
        // R5/R6: each quadrant with chosen bits
        img[2] = 8'h01;
        run(32'h0000_0010, 0, 1, BASE, 0, 0, 0, "R6 bit0 set");
        run(32'h0000_0011, 0, 1, BASE, 2, 0, 0, "R6 bit1 clear");
        img[1024 + 2] = 8'h80;
        run(32'hC000_0017, 0, 1, BASE, 1, 0, 0, "R5 high read");
        img[2048 + 1023] = 8'h7F;
        run(32'h0000_1FFF, 1, 1, BASE, 1, 0, 0, "R5 low write top");
        img[4095] = 8'h01;
        run(32'hC000_1FF8, 1, 1, BASE, 1, 0, 0, "R5 high write top");
        // R5/R6: spread of indices over all quadrants
        for (int i = 0; i < 40; i++) begin
            logic [31:0] ix;
            ix = ((i % 2) != 0 ? 32'hC000_0000 : 32'h0) + 32'((i * 1237 + 5) % 8192);
            run(ix, (i / 2) % 2 == 1, 1, BASE, i % 4, 0, 0, "R5/R6 sweep");
        end
        // R7: memory error
        img[5] = 8'h00;
        run(32'h0000_0028, 0, 1, BASE, 1, 1, 0, "R7 mem error");
        // R8: response held
        run(32'h0000_0028, 0, 1, BASE, 1, 0, 3, "R8 held permit");
        run(32'h0000_2000, 0, 1, BASE, 1, 0, 4, "R8 held trap");
        // R10: bitmap change is seen on repeat
        img[3072 + 10] = 8'h00;
        run(32'hC000_0052, 1, 1, BASE, 1, 0, 0, "R10 first");
        img[3072 + 10] = 8'h04;
        run(32'hC000_0052, 1, 1, BASE, 1, 0, 0, "R10 changed");
        mon_on = 0;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule